// File: doc/BRIEF.md
# Eight-Channel Output Compare Unit with Master Channel

This block sits beside a free-running 16-bit timer and turns count matches into pin activity. Each channel holds a compare value; when the timer advances onto that value the channel raises its flag and applies its configured action (toggle, clear or set) to its own pin. The top channel is a master: when it fires, it writes a masked data pattern onto any of the port pins, overriding whatever the other channels did in the same cycle. It can also request a timer reset.

Software reaches the block through a simple write/read register port. Writing a force register triggers a channel's action at once, without setting its flag. Each pin has a general-purpose data latch and a direction bit. While a pin is under compare control it is driven from the compare logic, and port writes only update the latch. The latched value reaches the pin once compare control is released.

Top module: `oc_master_unit`

## Requirements
- R1: After reset all flags, pin outputs, pin enables, `cnt_clr` and all registers read as zero.
- R2: A channel matches only in a cycle with `cnt_adv` high and `cnt` equal to its compare register (address i for channel i). A match sets the channel flag (bit i of `flags`) at the next clock edge.
- R3: Channels 0 to 6 each have a 2-bit action field at bits [2i+1:2i] of address 8: 0 none, 1 toggle, 2 clear, 3 set. On a match the action is applied to the channel's pin level, which is visible one cycle later.
- R4: Writing 1 to bit i of address 12 applies channel i's action (or, for channel 7, its pattern) at once without setting any flag. A forced channel with action 0 changes nothing.
- R5: When channel 7 fires by match or force, each pin j whose bit j is set in the mask (address 9) takes bit j of the pattern (address 10). This overrides any other channel's action on that pin in the same cycle. Pins whose mask bit is clear are unaffected.
- R6: With bit 0 of address 11 set, a channel 7 match drives `cnt_clr` high in that same cycle, even when channel 7's pin is not under compare control. With the bit clear, `cnt_clr` stays low.
- R7: A pin under compare control (nonzero action field, or its mask bit set) has `pin_oe` high whatever its direction bit (address 15), and the stored direction bit reads back unchanged.
- R8: A write to the port latch (address 14) does not change a pin under compare control. The latch reads back the written value, and the value appears on the pin once control is released.
- R9: Writing 1 to bit i of address 13 clears flag i. A written 0 leaves a flag unchanged.
- R10: A pin with action 0 and mask bit clear is in general-purpose use: `pin_out` shows the port latch bit and `pin_oe` the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | CW (16) | Register write data |
| rd_addr | input | AW (4) | Register read address |
| rd_data | output | CW (16) | Register read data, combinational |
| cnt | input | CW (16) | Current timer count |
| cnt_adv | input | 1 | High in cycles where the count has just advanced |
| cnt_clr | output | 1 | Request to reset the timer count to zero |
| pin_out | output | NCH (8) | Pin output levels |
| pin_oe | output | NCH (8) | Pin output enables |
| flags | output | NCH (8) | Channel match flags |

## Verification
The bench builds the block with its defaults: eight channels, a 16-bit count and a 4-bit address. With these values the master mask spans a full byte, so one test can cover a masked pin fought over by a slave channel, a masked pin of the master itself and an unmasked bystander. The full address space is reachable, so every register, including the write-only force and flag-clear strobes, is exercised. Small compare values stand in for the 16-bit range, since matching is a plain equality and needs no wraparound to reach its corner cases.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TOG  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_SET  = 2'd3
  } act_e;

  // New pin level produced by a slave channel action.
  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_TOG: return ~cur;
      ACT_CLR: return 1'b0;
      ACT_SET: return 1'b1;
      default: return cur;
    endcase
  endfunction

  // Master overlay: masked pattern bits replace the current levels.
  function automatic logic master_bit(logic msk, logic pat, logic cur);
    return msk ? pat : cur;
  endfunction

endpackage

// File: rtl/oc_regs.sv
module oc_regs #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [CW-1:0]            rd_data,
  input  logic [NCH-1:0]           flags,
  output logic [NCH-1:0][CW-1:0]   cmp,
  output logic [NCH-2:0][1:0]      mode,
  output logic [NCH-1:0]           mask,
  output logic [NCH-1:0]           mdata,
  output logic                     rst_en,
  output logic [NCH-1:0]           force_p,
  output logic [NCH-1:0]           clr_p,
  output logic [NCH-1:0]           port_q,
  output logic [NCH-1:0]           dir_q
);
  localparam int MW      = 2 * (NCH - 1);
  localparam int A_MODE  = NCH;
  localparam int A_MASK  = NCH + 1;
  localparam int A_DATA  = NCH + 2;
  localparam int A_CTRL  = NCH + 3;
  localparam int A_FORCE = NCH + 4;
  localparam int A_FLAG  = NCH + 5;
  localparam int A_PORT  = NCH + 6;
  localparam int A_DIR   = NCH + 7;

  function automatic logic hit_addr(logic [AW-1:0] a, int idx);
    return a == AW'(idx);
  endfunction

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n)                            cmp[i] <= '0;
      else if (wr_en && hit_addr(wr_addr, i)) cmp[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= '0;
      mask   <= '0;
      mdata  <= '0;
      rst_en <= 1'b0;
      port_q <= '0;
      dir_q  <= '0;
    end else if (wr_en) begin
      if (hit_addr(wr_addr, A_MODE)) mode   <= wr_data[MW-1:0];
      if (hit_addr(wr_addr, A_MASK)) mask   <= wr_data[NCH-1:0];
      if (hit_addr(wr_addr, A_DATA)) mdata  <= wr_data[NCH-1:0];
      if (hit_addr(wr_addr, A_CTRL)) rst_en <= wr_data[0];
      if (hit_addr(wr_addr, A_PORT)) port_q <= wr_data[NCH-1:0];
      if (hit_addr(wr_addr, A_DIR))  dir_q  <= wr_data[NCH-1:0];
    end
  end

  // Write-only strobes: one-cycle pulses, never stored.
  assign force_p = (wr_en && hit_addr(wr_addr, A_FORCE)) ? wr_data[NCH-1:0] : '0;
  assign clr_p   = (wr_en && hit_addr(wr_addr, A_FLAG))  ? wr_data[NCH-1:0] : '0;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++)
      if (hit_addr(rd_addr, i)) rd_data = cmp[i];
    if (hit_addr(rd_addr, A_MODE)) rd_data = CW'(mode);
    if (hit_addr(rd_addr, A_MASK)) rd_data = CW'(mask);
    if (hit_addr(rd_addr, A_DATA)) rd_data = CW'(mdata);
    if (hit_addr(rd_addr, A_CTRL)) rd_data = CW'(rst_en);
    if (hit_addr(rd_addr, A_FLAG)) rd_data = CW'(flags);
    if (hit_addr(rd_addr, A_PORT)) rd_data = CW'(port_q);
    if (hit_addr(rd_addr, A_DIR))  rd_data = CW'(dir_q);
  end

endmodule

// File: rtl/oc_action.sv
module oc_action
  import oc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CW-1:0]          cnt,
  input  logic                   cnt_adv,
  input  logic [NCH-1:0][CW-1:0] cmp,
  input  logic [NCH-2:0][1:0]    mode,
  input  logic [NCH-1:0]         mask,
  input  logic [NCH-1:0]         mdata,
  input  logic                   rst_en,
  input  logic [NCH-1:0]         force_p,
  input  logic [NCH-1:0]         clr_p,
  output logic [NCH-1:0]         oc_q,
  output logic [NCH-1:0]         flags,
  output logic                   cnt_clr
);
  localparam int M = NCH - 1;

  logic [NCH-1:0] hit;    // real count match
  logic [NCH-1:0] fire;   // match or software force
  logic [NCH-1:0] oc_nxt;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i]  = cnt_adv && (cnt == cmp[i]);
    assign fire[i] = hit[i] | force_p[i];
  end

  always_comb begin
    oc_nxt = oc_q;
    for (int i = 0; i < M; i++)
      if (fire[i]) oc_nxt[i] = apply_act(act_e'(mode[i]), oc_q[i]);
    if (fire[M])
      for (int j = 0; j < NCH; j++)
        oc_nxt[j] = master_bit(mask[j], mdata[j], oc_nxt[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oc_q  <= '0;
      flags <= '0;
    end else begin
      oc_q  <= oc_nxt;
      flags <= (flags & ~clr_p) | hit;
    end
  end

  assign cnt_clr = hit[M] & rst_en;

  for (genvar i = 0; i < NCH; i++) begin : g_ast
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i]); // R2
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (force_p[i] && !hit[i] && !flags[i]) |=> !flags[i]); // R4
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_p[i] && !hit[i]) |=> !flags[i]); // R9
    AST_MASTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[M] && mask[i]) |=> (oc_q[i] == $past(mdata[i]))); // R5
  end

  for (genvar i = 0; i < M; i++) begin : g_ast_act
    AST_SET_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && mode[i] == ACT_SET && !(fire[M] && mask[i])) |=> oc_q[i]); // R3
    AST_TOG_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && mode[i] == ACT_TOG && !(fire[M] && mask[i]))
        |=> (oc_q[i] != $past(oc_q[i]))); // R3
  end

endmodule

// File: rtl/oc_pinmux.sv
module oc_pinmux #(
  parameter int NCH = 8
) (
  input  logic [NCH-2:0][1:0] mode,
  input  logic [NCH-1:0]      mask,
  input  logic [NCH-1:0]      oc_q,
  input  logic [NCH-1:0]      port_q,
  input  logic [NCH-1:0]      dir_q,
  output logic [NCH-1:0]      ctl,
  output logic [NCH-1:0]      pin_out,
  output logic [NCH-1:0]      pin_oe
);
  for (genvar i = 0; i < NCH; i++) begin : g_pin
    if (i < NCH - 1) begin : g_slave
      assign ctl[i] = (mode[i] != 2'd0) | mask[i];
    end else begin : g_master
      assign ctl[i] = mask[i];
    end
    assign pin_out[i] = ctl[i] ? oc_q[i] : port_q[i];
    assign pin_oe[i]  = ctl[i] | dir_q[i];
  end
endmodule

// File: rtl/oc_master_unit.sv
module oc_master_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = $clog2(2 * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic [CW-1:0]  cnt,
  input  logic           cnt_adv,
  output logic           cnt_clr,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] pin_oe,
  output logic [NCH-1:0] flags
);
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-2:0][1:0]    mode;
  logic [NCH-1:0]         mask, mdata, force_p, clr_p, port_q, dir_q;
  logic [NCH-1:0]         oc_q, ctl;
  logic                   rst_en;

  oc_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flags(flags), .cmp(cmp), .mode(mode), .mask(mask), .mdata(mdata),
    .rst_en(rst_en), .force_p(force_p), .clr_p(clr_p),
    .port_q(port_q), .dir_q(dir_q)
  );

  oc_action #(.NCH(NCH), .CW(CW)) u_action (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_adv(cnt_adv), .cmp(cmp),
    .mode(mode), .mask(mask), .mdata(mdata), .rst_en(rst_en),
    .force_p(force_p), .clr_p(clr_p), .oc_q(oc_q), .flags(flags),
    .cnt_clr(cnt_clr)
  );

  oc_pinmux #(.NCH(NCH)) u_pinmux (
    .mode(mode), .mask(mask), .oc_q(oc_q), .port_q(port_q), .dir_q(dir_q),
    .ctl(ctl), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  AST_CLR_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> flags[NCH-1]); // R6

  for (genvar i = 0; i < NCH; i++) begin : g_top_ast
    AST_CTL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[i] |-> pin_oe[i]); // R7
    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i] && $past(ctl[i]) && oc_q[i] == $past(oc_q[i]))
        |-> (pin_out[i] == $past(pin_out[i]))); // R8
  end

endmodule

// File: tb/tb_oc_master_unit.sv
`timescale 1ns/1ps
module tb_oc_master_unit;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [CW-1:0]  wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [CW-1:0]  rd_data;
  logic [CW-1:0]  cnt = '0;
  logic           cnt_adv = 1'b0;
  logic           cnt_clr;
  logic [NCH-1:0] pin_out, pin_oe, flags;

  int checks = 0;
  int errors = 0;
  logic clr_seen;

  always #4 clk = ~clk;

  oc_master_unit #(.NCH(NCH), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt),
    .cnt_adv(cnt_adv), .cnt_clr(cnt_clr), .pin_out(pin_out),
    .pin_oe(pin_oe), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick(input logic [CW-1:0] c, input logic adv);
    @(negedge clk); cnt = c; cnt_adv = adv;
    #1 clr_seen = cnt_clr;
    @(negedge clk); cnt_adv = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    rd_addr = a; #1 d = rd_data;
  endtask

  function automatic logic [23:0] pins();
    return {pin_out, pin_oe, flags};
  endfunction

  // {op(1: 0 write, 1 tick), addr(4), data/count(16), out(8), oe(8), flags(8), req(4)}
  localparam int NV = 14;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h0010, 8'h00, 8'h00, 8'h00, 4'd3}, // R3 compare 0 = 0x10
    {1'b0, 4'd8,  16'h0001, 8'h00, 8'h01, 8'h00, 4'd3}, // R3 ch0 toggle
    {1'b1, 4'd0,  16'h0010, 8'h01, 8'h01, 8'h01, 4'd2}, // R2 match
    {1'b1, 4'd0,  16'h0011, 8'h01, 8'h01, 8'h01, 4'd2}, // R2 no match
    {1'b1, 4'd0,  16'h0010, 8'h00, 8'h01, 8'h01, 4'd3}, // R3 toggle back
    {1'b0, 4'd8,  16'h0003, 8'h00, 8'h01, 8'h01, 4'd3}, // R3 ch0 set
    {1'b1, 4'd0,  16'h0010, 8'h01, 8'h01, 8'h01, 4'd3}, // R3 set
    {1'b0, 4'd8,  16'h0002, 8'h01, 8'h01, 8'h01, 4'd3}, // R3 ch0 clear
    {1'b1, 4'd0,  16'h0010, 8'h00, 8'h01, 8'h01, 4'd3}, // R3 clear
    {1'b0, 4'd13, 16'h0001, 8'h00, 8'h01, 8'h00, 4'd9}, // R9 clear flag 0
    {1'b0, 4'd1,  16'h0020, 8'h00, 8'h01, 8'h00, 4'd3}, // R3 compare 1 = 0x20
    {1'b0, 4'd8,  16'h000E, 8'h00, 8'h03, 8'h00, 4'd3}, // R3 ch0 clear, ch1 set
    {1'b1, 4'd0,  16'h0020, 8'h02, 8'h03, 8'h02, 4'd2}, // R2 only ch1 matches
    {1'b1, 4'd0,  16'h0010, 8'h02, 8'h03, 8'h03, 4'd3}  // R3 clear on low pin
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] d;
    do_reset();

    // R1 reset state
    chk("R1 pins/flags", 32'(pins()), 32'h0);
    chk("R1 cnt_clr", 32'(cnt_clr), 32'h0);
    rd(4'd0, d);  chk("R1 compare readback", 32'(d), 32'h0);
    rd(4'd15, d); chk("R1 dir readback", 32'(d), 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [48:0] v;
      v = VEC[k];
      if (v[48]) tick(v[43:28], 1'b1);
      else       wr(v[47:44], v[43:28]);
      chk($sformatf("R%0d vector %0d", v[3:0], k), 32'(pins()), 32'(v[27:4]));
    end

    // R2 matching count without an advance strobe does nothing
    tick(16'h0020, 1'b0);
    chk("R2 no advance", 32'(pins()), 32'h020303);

    // R4 force
    do_reset();
    wr(4'd8, 16'h0001);
    wr(4'd12, 16'h0001);
    chk("R4 force toggles, no flag", 32'(pins()), 32'h010100);
    wr(4'd12, 16'h0002);
    chk("R4 force on idle channel", 32'(pins()), 32'h010100);

    // R5 master pattern overrides slave
    do_reset();
    wr(4'd0, 16'h0040);
    wr(4'd8, 16'h0003);
    wr(4'd7, 16'h0040);
    wr(4'd9, 16'h0081);
    wr(4'd10, 16'h0000);
    tick(16'h0040, 1'b1);
    chk("R5 master beats set", 32'(pins()), 32'h008181);
    chk("R6 disabled no clr", 32'(clr_seen), 32'h0);
    wr(4'd10, 16'h0083);
    wr(4'd12, 16'h0080);
    chk("R5 forced master, unmasked bit1 untouched", 32'(pins()), 32'h818181);

    // R9 write-zero keeps flags, write-one clears
    wr(4'd13, 16'h0000);
    chk("R9 write zero", 32'(flags), 32'h81);
    wr(4'd13, 16'h0080);
    chk("R9 write one", 32'(flags), 32'h01);

    // R6 counter reset request
    wr(4'd11, 16'h0001);
    tick(16'h0040, 1'b1);
    chk("R6 clr on match", 32'(clr_seen), 32'h1);
    tick(16'h0041, 1'b1);
    chk("R6 no clr off match", 32'(clr_seen), 32'h0);
    wr(4'd11, 16'h0000);
    tick(16'h0040, 1'b1);
    chk("R6 clr disabled", 32'(clr_seen), 32'h0);
    wr(4'd9, 16'h0000);
    wr(4'd11, 16'h0001);
    tick(16'h0040, 1'b1);
    chk("R6 clr with pin7 released", 32'(clr_seen), 32'h1);

    // R7 R8 R10 pin ownership
    do_reset();
    wr(4'd14, 16'h0004);
    chk("R10 latch drives pin, dir 0", 32'({pin_out, pin_oe}), 32'h0400);
    wr(4'd15, 16'h0004);
    chk("R10 dir enables pin", 32'({pin_out, pin_oe}), 32'h0404);
    wr(4'd8, 16'h0030);
    chk("R7 compare owns pin", 32'({pin_out, pin_oe}), 32'h0004);
    wr(4'd15, 16'h0000);
    chk("R7 oe ignores dir", 32'(pin_oe), 32'h04);
    rd(4'd15, d);
    chk("R7 dir stored", 32'(d), 32'h0);
    wr(4'd12, 16'h0004);
    wr(4'd14, 16'h0000);
    chk("R8 port write no effect", 32'(pin_out), 32'h04);
    rd(4'd14, d);
    chk("R8 latch readback", 32'(d), 32'h0);
    wr(4'd8, 16'h0000);
    chk("R8 latch after release", 32'({pin_out, pin_oe}), 32'h0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule